// File: doc/BRIEF.md
# Dual-Bank Flash Operation Controller

This block keeps the operating mode of a flash array that is split into two logical banks. The bank-address field selects one of four physical banks, and a parameter divides them into a lower and an upper logical bank. While one bank runs an embedded operation, the other bank keeps serving reads. The embedded operations are program, erase and identifier (autoselect) read. A command strobe carries a decoded command code and a bank address. A per-bank completion input tells the block when an embedded program or erase has finished. An erase can be suspended and resumed through the bank address of the bank doing the erase.

The block also decides when the data bus may be driven. It applies the chip-enable, output-enable and reset rules, and it applies a wake-up interval after reset. It reports standby. Standby comes from reset held low, or from chip-enable held inactive while no embedded operation is running.

The reset input also serves as the hardware reset at power-up. It is asynchronous and active low. Reads become valid once the wake-up interval that follows reset has run out. All control pins are plain levels or one-cycle strobes, with no handshake. The block has no data stream. The command input is a one-cycle strobe, and a command that is not accepted is either dropped or reported through the error pulse. Nothing applies back-pressure.

Top module: `dual_bank_flash_ctrl`

## Requirements
- R1: With the default split of 2, bank addresses 0 and 1 select logical bank 0, and bank addresses 2 and 3 select logical bank 1.
- R2: Mode encoding is 0 read, 1 identifier, 2 program, 3 erase, 4 erase-suspended. A start command has code 1 (identifier), 2 (program) or 3 (erase). It moves the addressed bank into the mode of the same value only when both banks are in read mode. The two banks are never both outside read mode.
- R3: A start command that is refused leaves both modes unchanged. It raises `cmd_err` for exactly the one cycle after the strobe. No other command raises `cmd_err`.
- R4: Code 4 sent to the address of a bank in erase mode moves that bank to erase-suspended. Code 4 sent to any other bank is ignored. Code 5 moves an erase-suspended bank back to erase mode.
- R5: A high `op_done` bit returns its bank from program or erase mode to read mode. It takes priority over a command in the same cycle. In identifier, suspended or read mode the bit is ignored.
- R6: Code 0 sent to a bank in identifier mode returns it to read mode. Codes 6 and 7 have no effect.
- R7: `data_oe` is high only while `rst_n` is high, `ce_n` is low, `oe_n` is low and the wake-up interval has elapsed.
- R8: `standby` is high while `rst_n` is low. It is also high while `ce_n` is high and neither bank is in program or erase mode.
- R9: While `rst_n` is low, both banks show read mode, without waiting for a clock edge, and `data_oe` is low.
- R10: After `rst_n` rises, `data_oe` stays low and commands are ignored until WAKE_CYCLES rising clock edges have passed.
- R11: Commands are ignored while `ce_n` is high. A bank in program or erase mode stays busy, and still completes on `op_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| cmd_stb | input | 1 | One-cycle command strobe |
| cmd_code | input | 3 | Decoded command code |
| bank_addr | input | BANK_AW | Physical bank address |
| op_done | input | 2 | Embedded-operation completion, one bit per logical bank |
| bank0_mode | output | 3 | Mode of logical bank 0 |
| bank1_mode | output | 3 | Mode of logical bank 1 |
| cmd_err | output | 1 | Refused start command, registered pulse |
| data_oe | output | 1 | Data bus driver enable |
| standby | output | 1 | Standby indication |

## Verification
The assertions take some things for granted about the inputs:
- `op_done` is a level sampled on clock edges.
- `rst_n` is released away from the active edge.
- A command and its bank address are held stable across the edge that captures them.

The bench follows these rules by driving every input one nanosecond after a rising edge and sampling there. It reaches each legal mode pair through the command interface itself, after a fresh reset and wake-up. From each pair it applies every command code, every bank address and every completion pattern, so the stimulus never forces the array into a mode pair the requirements forbid.

// File: rtl/flash_ctrl_pkg.sv
package flash_ctrl_pkg;

  typedef enum logic [2:0] {
    MODE_READ  = 3'd0,
    MODE_IDENT = 3'd1,
    MODE_PROG  = 3'd2,
    MODE_ERASE = 3'd3,
    MODE_SUSP  = 3'd4
  } bank_mode_e;

  localparam logic [2:0] CMD_EXIT    = 3'd0;
  localparam logic [2:0] CMD_IDENT   = 3'd1;
  localparam logic [2:0] CMD_PROG    = 3'd2;
  localparam logic [2:0] CMD_ERASE   = 3'd3;
  localparam logic [2:0] CMD_SUSPEND = 3'd4;
  localparam logic [2:0] CMD_RESUME  = 3'd5;

  function automatic logic is_start(input logic [2:0] code);
    return (code == CMD_IDENT) || (code == CMD_PROG) || (code == CMD_ERASE);
  endfunction

  function automatic logic is_busy(input bank_mode_e m);
    return (m == MODE_PROG) || (m == MODE_ERASE);
  endfunction

endpackage

// File: rtl/flash_wake_timer.sv
module flash_wake_timer #(
  parameter int WAKE_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic ready
);
  localparam int CW = $clog2(WAKE_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(WAKE_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_q != LIMIT)
      cnt_q <= cnt_q + 1'b1;
  end

  assign ready = (cnt_q == LIMIT);
endmodule

// File: rtl/flash_bank_fsm.sv
module flash_bank_fsm
  import flash_ctrl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hit,
  input  logic [2:0] code,
  input  logic       other_idle,
  input  logic       done,
  output bank_mode_e mode,
  output logic       reject
);
  bank_mode_e mode_q, mode_d;
  logic       start;

  assign start  = hit && is_start(code);
  assign reject = start && !(mode_q == MODE_READ && other_idle);

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_READ:  if (start && other_idle) mode_d = bank_mode_e'(code);
      MODE_IDENT: if (hit && code == CMD_EXIT) mode_d = MODE_READ;
      MODE_PROG:  if (done) mode_d = MODE_READ;
      MODE_ERASE: begin
        if (done)                            mode_d = MODE_READ;
        else if (hit && code == CMD_SUSPEND) mode_d = MODE_SUSP;
      end
      MODE_SUSP:  if (hit && code == CMD_RESUME) mode_d = MODE_ERASE;
      default:    mode_d = MODE_READ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_READ;
    else        mode_q <= mode_d;
  end

  assign mode = mode_q;
endmodule

// File: rtl/dual_bank_flash_ctrl.sv
module dual_bank_flash_ctrl
  import flash_ctrl_pkg::*;
#(
  parameter int BANK_AW     = 2,
  parameter int SPLIT       = 2,
  parameter int WAKE_CYCLES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ce_n,
  input  logic               oe_n,
  input  logic               cmd_stb,
  input  logic [2:0]         cmd_code,
  input  logic [BANK_AW-1:0] bank_addr,
  input  logic [1:0]         op_done,
  output logic [2:0]         bank0_mode,
  output logic [2:0]         bank1_mode,
  output logic               cmd_err,
  output logic               data_oe,
  output logic               standby
);
  localparam logic [BANK_AW-1:0] SPLIT_ADDR = BANK_AW'(SPLIT);

  logic       ready;
  logic       cmd_live;
  logic       target;
  logic [1:0] rej;
  logic       busy;
  bank_mode_e mode [2];

  flash_wake_timer #(.WAKE_CYCLES(WAKE_CYCLES)) u_wake (
    .clk   (clk),
    .rst_n (rst_n),
    .ready (ready)
  );

  assign cmd_live = cmd_stb && !ce_n && ready;
  assign target   = (bank_addr >= SPLIT_ADDR);

  for (genvar g = 0; g < 2; g++) begin : g_bank
    flash_bank_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .hit        (cmd_live && (target == 1'(g))),
      .code       (cmd_code),
      .other_idle (mode[1-g] == MODE_READ),
      .done       (op_done[g]),
      .mode       (mode[g]),
      .reject     (rej[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_err <= 1'b0;
    else        cmd_err <= |rej;
  end

  assign busy       = is_busy(mode[0]) || is_busy(mode[1]);
  assign standby    = !rst_n || (ce_n && !busy);
  assign data_oe    = rst_n && !ce_n && !oe_n && ready;
  assign bank0_mode = mode[0];
  assign bank1_mode = mode[1];
endmodule

// File: rtl/dbfc_checker.sv
module dbfc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       ce_n,
  input logic       oe_n,
  input logic       cmd_stb,
  input logic [1:0] op_done,
  input logic [2:0] bank0_mode,
  input logic [2:0] bank1_mode,
  input logic       cmd_err,
  input logic       data_oe,
  input logic       standby
);
  assert_one_bank_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bank0_mode != 3'd0 && bank1_mode != 3'd0));

  assert_err_after_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> $past(cmd_stb));

  assert_susp_from_erase0_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bank0_mode == 3'd4) |-> ($past(bank0_mode) == 3'd3 || $past(bank0_mode) == 3'd4));

  assert_susp_from_erase1_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bank1_mode == 3'd4) |-> ($past(bank1_mode) == 3'd3 || $past(bank1_mode) == 3'd4));

  assert_oe_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> (!ce_n && !oe_n));

  assert_standby_hiz_R8: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> !data_oe);

  assert_busy_holds0_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n && bank0_mode == 3'd2 && !op_done[0]) |=> (bank0_mode == 3'd2));

  assert_busy_holds1_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n && bank1_mode == 3'd3 && !op_done[1]) |=> (bank1_mode == 3'd3 || bank1_mode == 3'd4));
endmodule

bind dual_bank_flash_ctrl dbfc_checker u_dbfc_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .ce_n       (ce_n),
  .oe_n       (oe_n),
  .cmd_stb    (cmd_stb),
  .op_done    (op_done),
  .bank0_mode (bank0_mode),
  .bank1_mode (bank1_mode),
  .cmd_err    (cmd_err),
  .data_oe    (data_oe),
  .standby    (standby)
);

// File: tb/tb_dual_bank_flash_ctrl.sv
`timescale 1ns/100ps
module tb_dual_bank_flash_ctrl;
  localparam int WAKE = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce_n = 1'b1;
  logic       oe_n = 1'b1;
  logic       cmd_stb = 1'b0;
  logic [2:0] cmd_code = '0;
  logic [1:0] bank_addr = '0;
  logic [1:0] op_done = '0;
  logic [2:0] bank0_mode, bank1_mode;
  logic       cmd_err, data_oe, standby;

  int  n_run = 0;
  int  n_fail = 0;
  bit  finished = 1'b0;

  always #2 clk = ~clk;

  dual_bank_flash_ctrl #(.BANK_AW(2), .SPLIT(2), .WAKE_CYCLES(WAKE)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .cmd_stb(cmd_stb),
    .cmd_code(cmd_code), .bank_addr(bank_addr), .op_done(op_done),
    .bank0_mode(bank0_mode), .bank1_mode(bank1_mode), .cmd_err(cmd_err),
    .data_oe(data_oe), .standby(standby)
  );

  task automatic check(string req, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    cmd_stb = 0; op_done = '0; ce_n = 1'b0; oe_n = 1'b1;
    rst_n = 1'b0;
    tick();
    rst_n = 1'b1;
    repeat (WAKE) tick();
  endtask

  task automatic issue(int code, int addr);
    cmd_code = 3'(code); bank_addr = 2'(addr); cmd_stb = 1'b1;
    tick();
    cmd_stb = 1'b0;
  endtask

  function automatic int model_next(int m, int o, bit hit, int code, bit done);
    bit start = hit && (code >= 1 && code <= 3);
    case (m)
      0: return (start && o == 0) ? code : 0;
      1: return (hit && code == 0) ? 0 : 1;
      2: return done ? 0 : 2;
      3: return done ? 0 : ((hit && code == 4) ? 4 : 3);
      4: return (hit && code == 5) ? 3 : 4;
      default: return 0;
    endcase
  endfunction

  function automatic bit model_err(int m, int o, bit hit, int code);
    return hit && (code >= 1 && code <= 3) && !(m == 0 && o == 0);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R9: reset state, held low, with CE and OE asserted
    ce_n = 1'b0; oe_n = 1'b0; rst_n = 1'b0;
    tick(); tick();
    check("R9", "bank0 mode in reset", int'(bank0_mode), 0);
    check("R9", "bank1 mode in reset", int'(bank1_mode), 0);
    check("R9", "data_oe in reset", int'(data_oe), 0);
    check("R8", "standby in reset", int'(standby), 1);

    // R10: wake-up interval; a command at the first edge is ignored
    rst_n = 1'b1;
    issue(3, 0);
    check("R10", "erase during wake ignored", int'(bank0_mode), 0);
    for (int k = 2; k < WAKE; k++) begin
      tick();
      check("R10", "data_oe during wake", int'(data_oe), 0);
    end
    tick();
    check("R10", "data_oe after wake", int'(data_oe), 1);

    // R7: chip-enable / output-enable gating
    for (int c = 0; c < 2; c++) begin
      for (int o = 0; o < 2; o++) begin
        ce_n = 1'(c); oe_n = 1'(o); #1;
        check("R7", "data_oe gating", int'(data_oe), (c == 0 && o == 0) ? 1 : 0);
      end
    end
    oe_n = 1'b1; ce_n = 1'b0;

    // R11 and R8: busy bank continues while deselected, commands ignored
    do_reset();
    issue(2, 1);
    check("R11", "program started", int'(bank0_mode), 2);
    ce_n = 1'b1; #1;
    check("R8", "no standby while busy", int'(standby), 0);
    issue(3, 3);
    check("R11", "command ignored while deselected", int'(bank1_mode), 0);
    check("R11", "no error while deselected", int'(cmd_err), 0);
    check("R11", "program still running", int'(bank0_mode), 2);
    op_done = 2'b01; tick(); op_done = '0;
    check("R11", "program completes deselected", int'(bank0_mode), 0);
    check("R8", "standby once idle", int'(standby), 1);
    ce_n = 1'b0; #1;
    check("R8", "standby left on select", int'(standby), 0);

    // R9: reset aborts an embedded erase without a clock edge
    do_reset();
    issue(3, 2);
    check("R9", "erase started", int'(bank1_mode), 3);
    #1 rst_n = 1'b0; #0.5;
    check("R9", "async reset returns read", int'(bank1_mode), 0);
    check("R9", "data_oe low in reset", int'(data_oe), 0);
    rst_n = 1'b1;

    // Sweep: every legal mode pair x every code x every address x every done
    for (int s = 0; s < 9; s++) begin
      for (int code = 0; code < 8; code++) begin
        for (int addr = 0; addr < 4; addr++) begin
          for (int d = 0; d < 4; d++) begin
            int b, kind, em0, em1, tb, n0, n1;
            bit h0, h1, e;
            do_reset();
            b = (s <= 4) ? 0 : 1;
            kind = (s == 0) ? 0 : ((s - 1) % 4) + 1;
            if (kind != 0) begin
              issue((kind == 4) ? 3 : kind, b * 2);
              if (kind == 4) issue(4, b * 2);
            end
            em0 = (b == 0) ? kind : 0;
            em1 = (b == 1) ? kind : 0;
            if (code == 0 && addr == 0 && d == 0) begin
              check("R2", "setup bank0", int'(bank0_mode), em0);
              check("R4", "setup bank1", int'(bank1_mode), em1);
            end
            tb = (addr >= 2) ? 1 : 0;   // R1 mapping
            h0 = (tb == 0); h1 = (tb == 1);
            n0 = model_next(em0, em1, h0, code, d[0]);
            n1 = model_next(em1, em0, h1, code, d[1]);
            e  = model_err(em0, em1, h0, code) || model_err(em1, em0, h1, code);
            cmd_code = 3'(code); bank_addr = 2'(addr); op_done = 2'(d); cmd_stb = 1'b1;
            tick();
            cmd_stb = 1'b0; op_done = '0;
            check("R1", "sweep bank0 mode", int'(bank0_mode), n0);
            check("R2", "sweep bank1 mode", int'(bank1_mode), n1);
            check("R3", "sweep cmd_err", int'(cmd_err), int'(e));
            tick();
            check("R3", "cmd_err one cycle", int'(cmd_err), 0);
            if (code == 4 || code == 5)
              check("R4", "suspend/resume result", int'(bank0_mode) + 8 * int'(bank1_mode), n0 + 8 * n1);
            if (d != 0)
              check("R5", "done result", int'(bank0_mode) + 8 * int'(bank1_mode), n0 + 8 * n1);
            if (code == 0 || code >= 6)
              check("R6", "exit/unused result", int'(bank0_mode) + 8 * int'(bank1_mode), n0 + 8 * n1);
            ce_n = 1'b1; #1;
            check("R8", "sweep standby",
                  int'(standby), (n0 == 2 || n0 == 3 || n1 == 2 || n1 == 3) ? 0 : 1);
            ce_n = 1'b0;
          end
        end
      end
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule